// File: doc/BRIEF.md
# Instruction Fetch, Decode and Operand-Address Resolver

This block is the front end of the instruction cycle in a small accumulator machine with 16-bit words and a 4096-word memory. After a start pulse gives it a program address, it fetches one instruction word and decodes the 3-bit operation code into eight one-hot lines. It also captures the direct/indirect flag. For memory-reference instructions it then works out the 12-bit operand address, which needs one extra memory read when the flag asks for indirection. It presents that address with a one-cycle ready strobe. It then parks until the execution stage returns a done pulse, and the next fetch follows from the incremented program counter.

Its sequencing comes from a small step counter decoded into one-hot timing steps. The counter advances once per cycle, stands still while a memory read is outstanding, and is cleared synchronously by the start pulse or by the done pulse. Every memory access goes out through a single 12-bit address register. The same register carries the resolved operand address to the execution stage.

Top module: `fe_ea_controller`

## Requirements
- R1: After synchronous reset the block is idle: `mem_rd` and `ea_ready` are 0, `op_lines` and `mode_i` are 0, and no read is issued, even if `done` pulses, until `start` is seen.
- R2: A `start` pulse loads the program counter from `start_addr`. The instruction read at that address is strobed one cycle after the edge that sampled `start`, for exactly one cycle.
- R3: Each later instruction is fetched from the previous fetch address plus one, wrapping from 4095 to 0.
- R4: An instruction word is laid out as mode flag in bit 15, operation code in bits 14..12 and address field in bits 11..0. From four cycles after the triggering edge, `op_lines` is one-hot with bit k set for code k, and `mode_i` equals bit 15.
- R5: A memory-reference instruction (code 0..6) with flag 0 issues no second read. `ea_ready` is high for exactly one cycle, four cycles after the triggering edge, with `ea_addr` equal to the address field.
- R6: A memory-reference instruction with flag 1 issues a second read at the address field four cycles after the triggering edge. `ea_ready` is high for one cycle, six cycles after that edge, with `ea_addr` equal to bits 11..0 of the word read; bits 15..12 of that word are ignored.
- R7: Code 7 (register or I/O class, either flag value) issues no pointer read and never raises `ea_ready`. The block parks after decoding.
- R8: While parked, `ea_addr`, `op_lines` and `mode_i` hold and no read is issued. A `done` pulse restarts the sequence, and the next fetch read is strobed one cycle after the edge that sampled `done`.
- R9: A `done` pulse that arrives before the block has parked has no effect on the sequence, the read addresses or the resolved address.
- R10: Read data is taken on the second edge after the strobe edge; the step counter does not advance during the cycle in which a read is strobed, so two reads are never strobed in consecutive cycles.
- R11: A `start` pulse at any point abandons the current instruction. The program counter is not incremented by the abandoned fetch, and fetching resumes from the new `start_addr` with R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load program counter and begin a fetch |
| start_addr | input | 12 | Program address taken on `start` |
| done | input | 1 | Execution finished; fetch the next instruction |
| mem_addr | output | 12 | Memory address (address register) |
| mem_rd | output | 1 | Read strobe; data is expected in the following cycle |
| mem_rdata | input | 16 | Memory read data |
| op_lines | output | 8 | One-hot decoded operation code |
| mode_i | output | 1 | Captured direct/indirect flag |
| ea_addr | output | 12 | Resolved operand address |
| ea_ready | output | 1 | One-cycle strobe: `ea_addr` is resolved |

## Verification
Every result is timed from the edge that sampled `start` or `done`. The fetch strobe is due one cycle later, the decode lines four cycles later, and the pointer read four cycles later. The ready strobe is due at four cycles for direct operands and six for indirect ones. The bench samples the ports one time unit after each edge for nine cycles per instruction and records the cycle index of every strobe. It compares those indices and addresses against values computed from the instruction word. Late or early behaviour therefore fails a check, and a wrong value also fails one. Done pulses placed inside the resolution window, and a restart placed in the middle of a fetch, are checked against the same arithmetic expectations.

// File: rtl/fe_pkg.sv
package fe_pkg;

    // Word layout: flag | opcode | address field (flag is the MSB)
    localparam int unsigned ADDR_W   = 12;
    localparam int unsigned OP_W     = 3;
    localparam int unsigned WORD_W   = 1 + OP_W + ADDR_W;
    localparam int unsigned OP_LINES = 1 << OP_W;

    // Timing steps used by the front end
    localparam int unsigned STEP_FETCH_ADDR = 0;
    localparam int unsigned STEP_FETCH_READ = 1;
    localparam int unsigned STEP_DECODE     = 2;
    localparam int unsigned STEP_RESOLVE    = 3;
    localparam int unsigned STEP_PTR_DONE   = 4;
    localparam int unsigned STEP_N          = STEP_PTR_DONE + 1;
    localparam int unsigned SC_W            = $clog2(STEP_N);

    typedef logic [ADDR_W-1:0]   addr_t;
    typedef logic [WORD_W-1:0]   word_t;
    typedef logic [OP_W-1:0]     opc_t;
    typedef logic [OP_LINES-1:0] oplines_t;

    typedef struct packed {
        logic  mode;
        opc_t  op;
        addr_t field;
    } instr_t;

    typedef enum logic [1:0] {
        CLS_MEMREF,
        CLS_REGREF,
        CLS_IOREF
    } iclass_t;

    typedef enum logic [1:0] {
        AR_KEEP,
        AR_FROM_PC,
        AR_FROM_IR,
        AR_FROM_MEM
    } ar_src_t;

    // Top decode line selects the non-memory classes; the flag splits them.
    function automatic iclass_t classify(input logic top_line, input logic mode);
        if (!top_line) begin
            return CLS_MEMREF;
        end
        return mode ? CLS_IOREF : CLS_REGREF;
    endfunction

    function automatic logic needs_pointer(input iclass_t cls, input logic mode);
        return (cls == CLS_MEMREF) && mode;
    endfunction

    function automatic instr_t split_word(input word_t w);
        return instr_t'(w);
    endfunction

endpackage

// File: rtl/fe_step_seq.sv
module fe_step_seq #(
    parameter int unsigned STEPS = 5,
    localparam int unsigned CW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    output logic [STEPS-1:0] step_oh
);

    logic [CW-1:0] sc_q;

    // Sequence counter: synchronous clear wins over advance.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sc_q <= '0;
        end else if (adv) begin
            sc_q <= sc_q + CW'(1);
        end
    end

    // One-hot timing step decode, one comparator per step.
    for (genvar s = 0; s < STEPS; s++) begin : g_step
        assign step_oh[s] = (sc_q == CW'(s));
    end

endmodule

// File: rtl/fe_line_decoder.sv
module fe_line_decoder #(
    parameter int unsigned IN_W = 3,
    localparam int unsigned N   = 1 << IN_W
) (
    input  logic [IN_W-1:0] sel,
    output logic [N-1:0]    lines
);

    for (genvar k = 0; k < N; k++) begin : g_line
        assign lines[k] = (sel == IN_W'(k));
    end

endmodule

// File: rtl/fe_addr_regs.sv
module fe_addr_regs
    import fe_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pc_load,
    input  logic [AW-1:0] pc_load_val,
    input  logic          pc_inc,
    input  logic          ir_load,
    input  ar_src_t       ar_src,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] ar,
    output logic [DW-1:0] ir
);

    logic [AW-1:0] pc_q;
    logic [AW-1:0] ar_q;
    logic [DW-1:0] ir_q;
    logic [AW-1:0] ar_next;

    // Program counter: a load beats an increment; the increment wraps.
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (pc_load) begin
            pc_q <= pc_load_val;
        end else if (pc_inc) begin
            pc_q <= pc_q + AW'(1);
        end
    end

    // Instruction register takes the fetched word.
    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q <= '0;
        end else if (ir_load) begin
            ir_q <= mem_rdata;
        end
    end

    // Address register: the only path to memory.
    always_comb begin
        unique case (ar_src)
            AR_FROM_PC:  ar_next = pc_q;
            AR_FROM_IR:  ar_next = ir_q[AW-1:0];
            AR_FROM_MEM: ar_next = mem_rdata[AW-1:0];
            default:     ar_next = ar_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ar_q <= '0;
        end else begin
            ar_q <= ar_next;
        end
    end

    assign pc = pc_q;
    assign ar = ar_q;
    assign ir = ir_q;

endmodule

// File: rtl/fe_ea_controller.sv
module fe_ea_controller
    import fe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic                done,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_rd,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic [OP_LINES-1:0] op_lines,
    output logic                mode_i,
    output logic [ADDR_W-1:0]   ea_addr,
    output logic                ea_ready
);

    // Control state
    logic     running_q;   // a start has been seen since reset
    logic     pending_q;   // a read was strobed last cycle
    logic     held_q;      // parked, waiting for done
    oplines_t op_lines_q;
    logic     mode_q;

    logic [STEP_N-1:0] step_oh;
    addr_t    pc;
    addr_t    ar;
    word_t    ir;
    instr_t   ir_f;
    oplines_t dec_lines;

    logic    live;
    logic    in_t0, in_t1, in_t2, in_t3, in_t4;
    iclass_t cls;
    logic    want_ptr;
    logic    ready_now;
    logic    park_now;
    logic    seq_adv;
    logic    seq_clr;
    logic    pc_inc;
    ar_src_t ar_src;

    // Step counter and its one-hot decode
    fe_step_seq #(
        .STEPS (STEP_N)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .clr     (seq_clr),
        .adv     (seq_adv),
        .step_oh (step_oh)
    );

    // PC / AR / IR
    fe_addr_regs #(
        .AW (ADDR_W),
        .DW (WORD_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .pc_load     (start),
        .pc_load_val (start_addr),
        .pc_inc      (pc_inc),
        .ir_load     (pc_inc),
        .ar_src      (ar_src),
        .mem_rdata   (mem_rdata),
        .pc          (pc),
        .ar          (ar),
        .ir          (ir)
    );

    assign ir_f = split_word(ir);

    // Opcode to eight lines
    fe_line_decoder #(
        .IN_W (OP_W)
    ) u_dec (
        .sel   (ir_f.op),
        .lines (dec_lines)
    );

    // A step acts only while running, not parked, and not being restarted.
    assign live  = running_q && !held_q && !start;
    assign in_t0 = live && step_oh[STEP_FETCH_ADDR];
    assign in_t1 = live && step_oh[STEP_FETCH_READ];
    assign in_t2 = live && step_oh[STEP_DECODE];
    assign in_t3 = live && step_oh[STEP_RESOLVE];
    assign in_t4 = live && step_oh[STEP_PTR_DONE];

    assign cls      = classify(op_lines_q[OP_LINES-1], mode_q);
    assign want_ptr = in_t3 && needs_pointer(cls, mode_q);

    // A read is strobed once; the following cycle receives the data.
    assign mem_rd = (in_t1 || want_ptr) && !pending_q;

    // Fetch data arrives: load IR, bump PC.
    assign pc_inc = in_t1 && pending_q;

    // Direct memory reference resolves at T3, indirect at T4.
    assign ready_now = (in_t3 && (cls == CLS_MEMREF) && !mode_q) || in_t4;
    assign park_now  = ready_now || (in_t3 && (cls != CLS_MEMREF));

    // The counter stands still on a strobe cycle and moves on the data cycle.
    assign seq_adv = in_t0 || in_t2 || ((in_t1 || want_ptr) && pending_q);
    assign seq_clr = start || (held_q && done);

    always_comb begin
        ar_src = AR_KEEP;
        if (in_t0) begin
            ar_src = AR_FROM_PC;
        end else if (in_t2) begin
            ar_src = AR_FROM_IR;
        end else if (want_ptr && pending_q) begin
            ar_src = AR_FROM_MEM;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q  <= 1'b0;
            pending_q  <= 1'b0;
            held_q     <= 1'b0;
            op_lines_q <= '0;
            mode_q     <= 1'b0;
        end else begin
            if (start) begin
                running_q <= 1'b1;
            end
            pending_q <= mem_rd;
            if (seq_clr) begin
                held_q <= 1'b0;
            end else if (park_now) begin
                held_q <= 1'b1;
            end
            if (in_t2) begin
                op_lines_q <= dec_lines;
                mode_q     <= ir_f.mode;
            end
        end
    end

    assign mem_addr = ar;
    assign ea_addr  = ar;
    assign ea_ready = ready_now;
    assign op_lines = op_lines_q;
    assign mode_i   = mode_q;

endmodule

// File: rtl/fe_ea_checker.sv
module fe_ea_checker
    import fe_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                done,
    input logic                mem_rd,
    input logic                ea_ready,
    input logic [ADDR_W-1:0]   ea_addr,
    input logic [OP_LINES-1:0] op_lines,
    input logic                mode_i,
    input logic                held_q,
    input logic                running_q,
    input logic [STEP_N-1:0]   step_oh
);

    // R1: nothing happens before the first start
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !running_q |-> (!mem_rd && !ea_ready));

    // R4: decoded lines never carry more than one code
    a_r4_lines_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(op_lines));

    // R5: the ready strobe lasts a single cycle
    a_r5_ready_single: assert property (@(posedge clk) disable iff (rst)
        ea_ready |=> !ea_ready);

    // R6: an indirect result follows a pointer read two cycles earlier, a direct one does not
    a_r6_ready_after_ptr: assert property (@(posedge clk) disable iff (rst)
        ea_ready |-> ($past(mem_rd, 2) == mode_i));

    // R7: the register / I/O class never reports an operand address
    a_r7_no_ready_top_code: assert property (@(posedge clk) disable iff (rst)
        ea_ready |-> !op_lines[OP_LINES-1]);

    // R8: while parked the results hold and memory is left alone
    a_r8_parked_stable: assert property (@(posedge clk) disable iff (rst)
        (held_q && !done && !start) |=> ($stable(ea_addr) && $stable(op_lines) && !mem_rd));

    // R10: exactly one timing step is active
    a_r10_step_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(step_oh) == 1);

    // R10: the step counter stands still across a strobe
    a_r10_step_frozen: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !start) |=> $stable(step_oh));

    // R10: strobes never come back to back
    a_r10_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

endmodule

bind fe_ea_controller fe_ea_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .done      (done),
    .mem_rd    (mem_rd),
    .ea_ready  (ea_ready),
    .ea_addr   (ea_addr),
    .op_lines  (op_lines),
    .mode_i    (mode_i),
    .held_q    (held_q),
    .running_q (running_q),
    .step_oh   (step_oh)
);

// File: tb/sim_fe_ea_controller.sv
`timescale 1ns/1ps
module sim_fe_ea_controller;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] start_addr = '0;
    logic        done = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd;
    logic [15:0] mem_rdata = '0;
    logic [7:0]  op_lines;
    logic        mode_i;
    logic [11:0] ea_addr;
    logic        ea_ready;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] mem [0:4095];

    always #5 clk = ~clk;

    // One-cycle-latency memory model
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    fe_ea_controller u0 (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .done(done),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .op_lines(op_lines), .mode_i(mode_i), .ea_addr(ea_addr), .ea_ready(ea_ready)
    );

    // Observation results of one instruction
    int          obs_rd_n;
    logic [11:0] obs_rd_a [0:3];
    int          obs_rd_c [0:3];
    int          obs_rdy_n;
    int          obs_rdy_c;
    logic [11:0] obs_ea;
    logic [11:0] obs_ea_end;
    logic [7:0]  obs_ops;
    logic [7:0]  obs_ops_end;
    logic        obs_mode;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic md, input logic [2:0] op, input logic [11:0] fld);
        return {md, op, fld};
    endfunction

    task automatic trig_start(input logic [11:0] a);
        start_addr = a;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic trig_done();
        done = 1'b1;
        @(posedge clk); #1;
        done = 1'b0;
    endtask

    // Cycle 0 is the cycle right after the triggering edge.
    task automatic observe(input int inj);
        obs_rd_n = 0; obs_rdy_n = 0; obs_rdy_c = -1; obs_ea = '0;
        for (int i = 0; i < 4; i++) begin obs_rd_a[i] = '0; obs_rd_c[i] = -1; end
        for (int cyc = 0; cyc <= 8; cyc++) begin
            if (cyc > 0) begin @(posedge clk); #1; end
            done = (inj != 0 && cyc == inj);
            if (mem_rd) begin
                if (obs_rd_n < 4) begin
                    obs_rd_a[obs_rd_n] = mem_addr;
                    obs_rd_c[obs_rd_n] = cyc;
                end
                obs_rd_n++;
            end
            if (ea_ready) begin
                obs_rdy_n++;
                obs_rdy_c = cyc;
                obs_ea = ea_addr;
            end
            if (cyc == 4) begin obs_ops = op_lines; obs_mode = mode_i; end
            if (cyc == 8) begin obs_ea_end = ea_addr; obs_ops_end = op_lines; end
        end
        done = 1'b0;
    endtask

    task automatic expect_instr(input logic [11:0] pc, input string pre);
        logic [15:0] w;
        logic [2:0]  op;
        logic        md;
        logic [11:0] fld;
        logic [15:0] ptr;
        w = mem[pc]; md = w[15]; op = w[14:12]; fld = w[11:0]; ptr = mem[fld];
        chk({pre, "R2/R3 fetch address"}, 32'(obs_rd_a[0]), 32'(pc));
        chk({pre, "R2/R8 fetch strobe cycle"}, 32'(obs_rd_c[0]), 32'd1);
        chk({pre, "R4 op lines"}, 32'(obs_ops), 32'(8'd1 << op));
        chk({pre, "R4 mode flag"}, 32'(obs_mode), 32'(md));
        chk({pre, "R8 lines hold"}, 32'(obs_ops_end), 32'(8'd1 << op));
        if (op == 3'd7) begin
            chk({pre, "R7 read count"}, 32'(obs_rd_n), 32'd1);
            chk({pre, "R7 no ready"}, 32'(obs_rdy_n), 32'd0);
        end else if (!md) begin
            chk({pre, "R5 read count"}, 32'(obs_rd_n), 32'd1);
            chk({pre, "R5 ready count"}, 32'(obs_rdy_n), 32'd1);
            chk({pre, "R5 ready cycle"}, 32'(obs_rdy_c), 32'd4);
            chk({pre, "R5 direct address"}, 32'(obs_ea), 32'(fld));
            chk({pre, "R8 address hold"}, 32'(obs_ea_end), 32'(fld));
        end else begin
            chk({pre, "R6/R10 read count"}, 32'(obs_rd_n), 32'd2);
            chk({pre, "R6 pointer read address"}, 32'(obs_rd_a[1]), 32'(fld));
            chk({pre, "R6/R10 pointer read cycle"}, 32'(obs_rd_c[1]), 32'd4);
            chk({pre, "R6 ready count"}, 32'(obs_rdy_n), 32'd1);
            chk({pre, "R6/R10 ready cycle"}, 32'(obs_rdy_c), 32'd6);
            chk({pre, "R6 indirect address"}, 32'(obs_ea), 32'(ptr[11:0]));
            chk({pre, "R8 address hold"}, 32'(obs_ea_end), 32'(ptr[11:0]));
        end
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state and idle behaviour
        chk("R1 mem_rd after reset", 32'(mem_rd), 32'd0);
        chk("R1 ea_ready after reset", 32'(ea_ready), 32'd0);
        chk("R1 op_lines after reset", 32'(op_lines), 32'd0);
        chk("R1 mode after reset", 32'(mode_i), 32'd0);
        trig_done();
        begin
            int strobes = 0;
            for (int c = 0; c < 6; c++) begin
                if (mem_rd || ea_ready) strobes++;
                @(posedge clk); #1;
            end
            chk("R1/R9 idle with done pulse", 32'(strobes), 32'd0);
        end

        // Sweep: every opcode with both flag values
        for (int k = 0; k < 16; k++) begin
            logic [2:0]  op;
            logic        md;
            logic [11:0] fld;
            op = 3'(k >> 1); md = k[0];
            fld = 12'(2000 + op * 16 + md * 8);
            if (k == 0) fld = 12'd0;
            if (k == 12) fld = 12'd4095;
            mem[100 + k] = mk(md, op, fld);
            if (md) mem[fld] = {4'(op + 8), 12'((op * 300 + 1350) % 4096)};
        end
        trig_start(12'd100);
        for (int k = 0; k < 16; k++) begin
            int inj;
            logic md;
            logic [2:0] op;
            md = k[0]; op = 3'(k >> 1);
            inj = 0;
            if (k % 3 == 1) inj = (md && op != 3'd7) ? 5 : 3;
            if (k > 0) trig_done();
            observe(inj);
            expect_instr(12'(100 + k), (inj != 0) ? "R9 early done: " : "");
        end

        // R3: program counter wrap
        mem[4094] = mk(1'b0, 3'd2, 12'd4095);
        mem[4095] = mk(1'b1, 3'd1, 12'd5);
        mem[5]    = 16'hBFFF;
        mem[0]    = mk(1'b0, 3'd0, 12'd0);
        trig_start(12'd4094);
        observe(0); expect_instr(12'd4094, "R3 wrap: ");
        trig_done();
        observe(0); expect_instr(12'd4095, "R3 wrap: ");
        trig_done();
        observe(0); expect_instr(12'd0, "R3 wrap: ");

        // R11: restart in the middle of a fetch
        mem[300]  = mk(1'b1, 3'd3, 12'd2100);
        mem[400]  = mk(1'b0, 3'd4, 12'd777);
        mem[401]  = mk(1'b1, 3'd5, 12'd2222);
        mem[2222] = 16'h7ABC;
        trig_start(12'd300);
        @(posedge clk); #1;
        @(posedge clk); #1;
        trig_start(12'd400);
        observe(0); expect_instr(12'd400, "R11 restart: ");
        trig_done();
        observe(0); expect_instr(12'd401, "R11 after restart: ");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule